// File: doc/BRIEF.md
# Flash erase command sequencer

This block is a behavioural model of the erase part of a NOR-flash command interface. It watches host write cycles. Each cycle in which `wr_en` is high counts as one completed write, carrying an address and a data byte. The block recognises the unlock sequences that start a chip erase or a sector erase. After a dedicated unlock-bypass command, it also accepts a shortened two-write form of both erases.

A sector erase opens an acceptance window. While the window is open, the host may add more sectors to an erase-select mask. A quiet timer closes the window once no sector write has arrived for a set number of clocks. After that, a simulated embedded erase runs. It has a preprogram phase and then an erase phase, and the length of each phase scales with the number of selected sectors. When the erase ends, the block returns to read mode with an empty mask. All durations are parameters given in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: The six writes AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, 30@sector address select exactly that sector and open the window (`win_open`=1, `read_mode`=0). Unlock addresses are compared on address bits [10:0]. The sector index is address bits [11:9], and sector s sets `erase_sel` bit s.
- R2: The same unlock and set-up writes ending in 10@0x555 set all eight bits of `erase_sel`. They raise `busy` and `prep_phase` right after the final write, and no window opens.
- R3: AA@0x555, 55@0x2AA, 20@0x555 sets `bypass_on`, which stays set until reset. In bypass mode a write of 80 at any address, followed by 30 at a sector address or 10, starts a sector erase or a chip erase.
- R4: Inside the window, every write of data 30 adds the sector given by its address and restarts the quiet timer. The window closes ACCEPT_CYC cycles after the last accepted write, and `busy` rises in the same cycle.
- R5: Inside the window, a write of data B0 leaves the selection unchanged and does not restart the timer.
- R6: Inside the window, a write of any data other than 30 or B0 clears `erase_sel`, closes the window and returns to read mode without starting an erase.
- R7: The embedded erase holds `prep_phase` high for n*PREP_CYC cycles and then keeps `busy` high for n*ERASE_CYC further cycles, where n is the number of selected sectors.
- R8: Writes made while `busy` is high change neither the selection nor the erase duration.
- R9: A write with an unexpected address or data at any step of a sequence returns the decoder to read mode, with no selection, no window and no erase.
- R10: A synchronous low `rst_n` clears `busy`, `prep_phase`, `win_open`, `erase_sel` and `bypass_on`, sets `read_mode`, and aborts any erase in progress.
- R11: When the erase completes, `busy` falls, `erase_sel` is zero and `read_mode` is 1. The window and the erase are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One host write completes in each cycle where this is high |
| wr_addr | input | 12 | Write address; bits [11:9] give the sector |
| wr_data | input | 8 | Write command byte |
| busy | output | 1 | Embedded erase running |
| prep_phase | output | 1 | Preprogram phase of the erase |
| win_open | output | 1 | Acceptance timer running (0 means expired or idle) |
| erase_sel | output | 8 | Sectors selected for erase |
| bypass_on | output | 1 | Unlock-bypass mode active |
| read_mode | output | 1 | Idle in read-array mode |

## Verification
The assertions check on every cycle the rules that hold at any time. The window and the erase never overlap. The mask is empty whenever the block is idle. Inside the window the selection only grows on a sector write and is cleared by a foreign command. `busy` stays high until the engine reports done. Bypass mode stays set once entered, and an erase start only arrives while the engine is idle. The bench scenarios show the cycle-exact behaviour: full and shortened command sequences, the window length after the last accepted write, the effect of the suspend code on the timer, phase durations that scale with the sector count, rejected malformed sequences, and a reset during an erase.

// File: rtl/fes_pkg.sv
// Package: command codes, unlock addresses and state types shared by the
// erase sequencer modules. Assumes 8-bit command bytes.
package fes_pkg;
    localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_SUSP   = 8'hB0;
    localparam logic [7:0]  CMD_BYPASS = 8'h20;
    localparam int          UNLK_W     = 11;
    localparam logic [10:0] ADR_UNLK_A = 11'h555;
    localparam logic [10:0] ADR_UNLK_B = 11'h2AA;

    typedef enum logic [2:0] {
        D_REST, D_U1, D_U2, D_SETUP, D_U3, D_U4, D_BSETUP
    } dec_state_t;

    typedef enum logic [1:0] {
        E_IDLE, E_PREP, E_ERASE
    } eng_state_t;
endpackage

// File: rtl/fes_decode.sv
// Module: command decoder. Tracks the unlock / set-up write sequence and
// emits one-cycle chip or sector start strobes combinationally on the
// final write. Assumes the caller blocks it (engaged) while a window or
// an erase is active; any mismatching write returns it to rest.
module fes_decode
    import fes_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              engaged,
    output logic              chip_go,
    output logic              sect_go,
    output logic [SECT_W-1:0] sect_idx,
    output logic              bypass,
    output logic              at_rest
);
    dec_state_t        st, st_nxt;
    logic              set_byp;
    logic              take;
    logic [UNLK_W-1:0] lo;

    assign lo       = wr_addr[UNLK_W-1:0];
    assign take     = wr_en && !engaged;
    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];
    assign at_rest  = (st == D_REST);

    // Next-state and strobe decode for one accepted write.
    always_comb begin
        st_nxt  = st;
        chip_go = 1'b0;
        sect_go = 1'b0;
        set_byp = 1'b0;
        if (take) begin
            st_nxt = D_REST;
            case (st)
                D_REST: begin
                    if (bypass && wr_data == CMD_SETUP)
                        st_nxt = D_BSETUP;
                    else if (lo == ADR_UNLK_A && wr_data == CMD_UNLK_A)
                        st_nxt = D_U1;
                end
                D_U1: if (lo == ADR_UNLK_B && wr_data == CMD_UNLK_B) st_nxt = D_U2;
                D_U2: begin
                    if (lo == ADR_UNLK_A && wr_data == CMD_SETUP)
                        st_nxt = D_SETUP;
                    else if (lo == ADR_UNLK_A && wr_data == CMD_BYPASS)
                        set_byp = 1'b1;
                end
                D_SETUP: if (lo == ADR_UNLK_A && wr_data == CMD_UNLK_A) st_nxt = D_U3;
                D_U3: if (lo == ADR_UNLK_B && wr_data == CMD_UNLK_B) st_nxt = D_U4;
                D_U4: begin
                    if (lo == ADR_UNLK_A && wr_data == CMD_CHIP) chip_go = 1'b1;
                    else if (wr_data == CMD_SECT)                sect_go = 1'b1;
                end
                D_BSETUP: begin
                    if (wr_data == CMD_CHIP)      chip_go = 1'b1;
                    else if (wr_data == CMD_SECT) sect_go = 1'b1;
                end
                default: st_nxt = D_REST;
            endcase
        end
    end

    // State and sticky bypass-mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= D_REST;
            bypass <= 1'b0;
        end else begin
            st <= st_nxt;
            if (set_byp) bypass <= 1'b1;
        end
    end

    // R3: bypass mode, once entered, persists until reset
    p_bypass_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> bypass);
    // R9: a start strobe needs an accepted write
    p_go_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_go || sect_go) |-> (wr_en && !engaged));
endmodule

// File: rtl/fes_accept.sv
// Module: acceptance window. Holds the erase-select mask, runs the quiet
// timer after a sector erase, adds sectors, tolerates the suspend code,
// aborts on any other write, and issues the erase start with its mask.
// Assumes ACCEPT_CYC >= 2.
module fes_accept
    import fes_pkg::*;
#(
    parameter int SECT_W     = 3,
    parameter int NSECT      = 8,
    parameter int ACCEPT_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [SECT_W-1:0] sect_idx,
    input  logic              sect_go,
    input  logic              chip_go,
    input  logic              eng_done,
    output logic              win_open,
    output logic [NSECT-1:0]  sel,
    output logic              start,
    output logic [NSECT-1:0]  start_mask
);
    localparam int TW = $clog2(ACCEPT_CYC + 1);

    logic [TW-1:0]    tmr;
    logic [NSECT-1:0] bit_sel;
    logic             expire;
    logic             foreign;

    assign bit_sel    = NSECT'(1) << sect_idx;
    assign expire     = (tmr == TW'(ACCEPT_CYC - 1));
    assign foreign    = wr_en && (wr_data != CMD_SUSP);
    assign start      = chip_go || (win_open && expire && !foreign);
    assign start_mask = chip_go ? {NSECT{1'b1}} : sel;

    // Window, timer and mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            sel      <= '0;
            tmr      <= '0;
        end else if (chip_go) begin
            sel <= {NSECT{1'b1}};
        end else if (sect_go) begin
            sel      <= bit_sel;
            win_open <= 1'b1;
            tmr      <= '0;
        end else if (win_open) begin
            if (wr_en && wr_data == CMD_SECT) begin
                sel <= sel | bit_sel;
                tmr <= '0;
            end else if (foreign) begin
                sel      <= '0;
                win_open <= 1'b0;
                tmr      <= '0;
            end else if (expire) begin
                win_open <= 1'b0;
                tmr      <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end else if (eng_done) begin
            sel <= '0;
        end
    end

    // R4: a sector write inside the window keeps it open and never drops sectors
    p_sel_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && wr_en && wr_data == CMD_SECT) |=>
        (win_open && ((sel & $past(sel)) == $past(sel))));
    // R5: suspend code leaves the selection untouched
    p_susp_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && wr_en && wr_data == CMD_SUSP) |=> (sel == $past(sel)));
    // R6: a foreign command aborts the window and empties the mask
    p_foreign_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && wr_en && wr_data != CMD_SUSP && wr_data != CMD_SECT) |=>
        (!win_open && sel == '0));
endmodule

// File: rtl/fes_engine.sv
// Module: embedded-erase engine. On start it counts the selected sectors,
// runs a preprogram phase then an erase phase, each PREP_CYC / ERASE_CYC
// cycles per sector, and pulses done on the last cycle. Assumes a start
// only arrives while idle and with at least one sector selected.
module fes_engine
    import fes_pkg::*;
#(
    parameter int NSECT     = 8,
    parameter int PREP_CYC  = 6,
    parameter int ERASE_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NSECT-1:0] start_mask,
    output logic             busy,
    output logic             prep_phase,
    output logic             done
);
    localparam int CW = $clog2(NSECT * (PREP_CYC + ERASE_CYC) + 1);

    eng_state_t st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nsel;
    logic [CW-1:0] n_in;

    // Population count of the incoming mask.
    always_comb begin
        n_in = '0;
        for (int i = 0; i < NSECT; i++) n_in = n_in + CW'(start_mask[i]);
    end

    assign busy       = (st != E_IDLE);
    assign prep_phase = (st == E_PREP);
    assign done       = (st == E_ERASE) && (cnt == CW'(1));

    // Phase sequencing and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= E_IDLE;
            cnt  <= '0;
            nsel <= '0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    st   <= E_PREP;
                    cnt  <= n_in * CW'(PREP_CYC);
                    nsel <= n_in;
                end
                E_PREP: begin
                    if (cnt == CW'(1)) begin
                        st  <= E_ERASE;
                        cnt <= nsel * CW'(ERASE_CYC);
                    end else cnt <= cnt - 1'b1;
                end
                E_ERASE: begin
                    if (cnt == CW'(1)) begin
                        st  <= E_IDLE;
                        cnt <= '0;
                    end else cnt <= cnt - 1'b1;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // R8: once running, the erase continues until done
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R7: the end of the preprogram phase is followed by the erase phase
    p_prep_then_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prep_phase) |-> busy);
    // R8: starts never arrive while an erase runs
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/flash_erase_seq.sv
// Module: top of the erase command sequencer. Ties the command decoder,
// the acceptance window and the erase engine together. Assumes one host
// write per cycle with wr_en high and ADDR_W > 11.
module flash_erase_seq #(
    parameter int ADDR_W     = 12,
    parameter int SECT_W     = 3,
    parameter int ACCEPT_CYC = 40,
    parameter int PREP_CYC   = 6,
    parameter int ERASE_CYC  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic                   busy,
    output logic                   prep_phase,
    output logic                   win_open,
    output logic [(1<<SECT_W)-1:0] erase_sel,
    output logic                   bypass_on,
    output logic                   read_mode
);
    localparam int NSECT = 1 << SECT_W;

    logic              chip_go, sect_go, at_rest, start, eng_done;
    logic [SECT_W-1:0] sect_idx;
    logic [NSECT-1:0]  start_mask;

    fes_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .engaged(win_open || busy), .chip_go(chip_go),
        .sect_go(sect_go), .sect_idx(sect_idx), .bypass(bypass_on),
        .at_rest(at_rest)
    );

    fes_accept #(.SECT_W(SECT_W), .NSECT(NSECT), .ACCEPT_CYC(ACCEPT_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sect_idx(sect_idx), .sect_go(sect_go), .chip_go(chip_go),
        .eng_done(eng_done), .win_open(win_open), .sel(erase_sel),
        .start(start), .start_mask(start_mask)
    );

    fes_engine #(.NSECT(NSECT), .PREP_CYC(PREP_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask),
        .busy(busy), .prep_phase(prep_phase), .done(eng_done)
    );

    assign read_mode = at_rest && !win_open && !busy;

    // R11: window and erase never overlap
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_open && busy));
    // R11: idle means an empty selection
    p_idle_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !busy) |-> (erase_sel == '0));
    // R2: a chip erase selects every sector as it begins
    p_chip_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(win_open) |-> (erase_sel == {NSECT{1'b1}}));
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
    localparam int ACC = 40;
    localparam int PC  = 6;
    localparam int EC  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, prep_phase, win_open, bypass_on, read_mode;
    logic [7:0]  erase_sel;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    flash_erase_seq #(.ADDR_W(12), .SECT_W(3), .ACCEPT_CYC(ACC),
                      .PREP_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .prep_phase(prep_phase),
        .win_open(win_open), .erase_sel(erase_sel), .bypass_on(bypass_on),
        .read_mode(read_mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] sa(input int s);
        return {s[2:0], 9'h000};
    endfunction

    task automatic count_win(output int c);
        c = 0;
        while (win_open && c < 1000) begin c++; @(negedge clk); end
    endtask

    task automatic count_prep(output int c);
        c = 0;
        while (prep_phase && c < 1000) begin c++; @(negedge clk); end
    endtask

    task automatic count_busy(output int c);
        c = 0;
        while (busy && c < 1000) begin c++; @(negedge clk); end
    endtask

    task automatic unlock_setup();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    endtask

    task automatic t_reset_state();
        chk("R10 read_mode after reset", read_mode, 1);
        chk("R10 busy after reset", busy, 0);
        chk("R10 win_open after reset", win_open, 0);
        chk("R10 erase_sel after reset", erase_sel, 0);
        chk("R10 bypass after reset", bypass_on, 0);
    endtask

    task automatic t_single();
        int c;
        unlock_setup(); wr(sa(5), 8'h30);
        chk("R1 window opens", win_open, 1);
        chk("R1 sector 5 selected", erase_sel, 8'h20);
        chk("R1 not read mode", read_mode, 0);
        count_win(c);  chk("R4 window length", c, ACC);
        chk("R4 busy at close", busy, 1);
        count_prep(c); chk("R7 prep 1 sector", c, PC);
        count_busy(c); chk("R7 erase 1 sector", c, EC);
        chk("R11 sel cleared", erase_sel, 0);
        chk("R11 read mode back", read_mode, 1);
    endtask

    task automatic t_multi();
        int c;
        unlock_setup(); wr(sa(3), 8'h30);
        idle(20); wr(sa(6), 8'h30);
        idle(20); wr(sa(0), 8'h30);
        chk("R4 three sectors", erase_sel, 8'h49);
        count_win(c);  chk("R4 window restarts", c, ACC);
        count_prep(c); chk("R7 prep 3 sectors", c, 3 * PC);
        count_busy(c); chk("R7 erase 3 sectors", c, 3 * EC);
    endtask

    task automatic t_suspend();
        int c;
        unlock_setup(); wr(sa(1), 8'h30);
        idle(10); wr(12'h555, 8'hB0);
        chk("R5 sel unchanged", erase_sel, 8'h02);
        chk("R5 window still open", win_open, 1);
        count_win(c);  chk("R5 timer not restarted", c, ACC - 11);
        count_prep(c); chk("R5 prep", c, PC);
        count_busy(c); chk("R5 erase", c, EC);
    endtask

    task automatic t_abort();
        unlock_setup(); wr(sa(2), 8'h30); wr(sa(5), 8'h30);
        wr(12'h000, 8'hF0);
        chk("R6 window closed", win_open, 0);
        chk("R6 sel cleared", erase_sel, 0);
        chk("R6 read mode", read_mode, 1);
        idle(ACC + 5);
        chk("R6 no erase", busy, 0);
    endtask

    task automatic t_chip();
        int c;
        unlock_setup(); wr(12'h555, 8'h10);
        chk("R2 busy at once", busy, 1);
        chk("R2 no window", win_open, 0);
        chk("R2 all sectors", erase_sel, 8'hFF);
        wr(sa(3), 8'h30); wr(12'h555, 8'hAA);
        chk("R8 sel unchanged", erase_sel, 8'hFF);
        count_prep(c); chk("R8 prep unchanged", c, 8 * PC - 2);
        count_busy(c); chk("R7 chip erase phase", c, 8 * EC);
        chk("R11 read mode after chip", read_mode, 1);
    endtask

    task automatic t_badseq();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h77);
        chk("R9 back to read", read_mode, 1);
        wr(sa(4), 8'h30);
        chk("R9 no stray window", win_open, 0);
        chk("R9 no stray sel", erase_sel, 0);
        unlock_setup(); wr(12'h555, 8'h44);
        idle(2);
        chk("R9 bad final no busy", busy, 0);
        chk("R9 bad final read", read_mode, 1);
        chk("R9 no bypass", bypass_on, 0);
    endtask

    task automatic t_bypass();
        int c;
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
        chk("R3 bypass on", bypass_on, 1);
        chk("R3 read mode in bypass", read_mode, 1);
        wr(12'h000, 8'h80); wr(sa(7), 8'h30);
        chk("R3 short sector erase", erase_sel, 8'h80);
        count_win(c);  chk("R3 window", c, ACC);
        count_prep(c); chk("R3 prep", c, PC);
        count_busy(c); chk("R3 erase", c, EC);
        chk("R3 bypass kept", bypass_on, 1);
        wr(12'h000, 8'h80); wr(12'h000, 8'h10);
        chk("R3 short chip erase busy", busy, 1);
        chk("R3 short chip erase sel", erase_sel, 8'hFF);
    endtask

    task automatic t_reset_abort();
        idle(5);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R10 busy aborted", busy, 0);
        chk("R10 prep aborted", prep_phase, 0);
        chk("R10 sel cleared", erase_sel, 0);
        chk("R10 bypass cleared", bypass_on, 0);
        chk("R10 read mode", read_mode, 1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single();
        t_multi();
        t_suspend();
        t_abort();
        t_chip();
        t_badseq();
        t_bypass();
        t_reset_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule